// File: doc/BRIEF.md
# Fault Event Detector with Sticky Interrupt Flag

This block watches one fault source for a timer and raises a fault interrupt request when that source shows a qualifying edge. The source is either the level read back from a fault pad or the output of an analog comparator. A select input picks one of them. Both candidates pass through the same front end: a two-flop synchronizer, an optional run-length noise canceler and an edge detector whose polarity is selectable. A detected edge sets a sticky flag.

The flag stays set until software clears it. It clears either when the core acknowledges the interrupt vector or when software writes a one to it. The write-one clear takes effect one synchronization cycle after the strobe. The interrupt request is the flag qualified by the block's own enable and by the global interrupt enable. The pad level is taken as read at the pad, so pad activity counts even while the pad drives as an output. The comparator and any timer shutdown action sit outside this block.

Top module: `fault_guard`

## Requirements
- R1: When `src_cmp_sel` is 0 the pad level feeds the front end and `cmp_out` has no effect on `flag`. When it is 1 the comparator output feeds the same front end and `pad_level` has no effect.
- R2: With `filt_en` at 0, a qualifying change of the selected source that is set up before clock edge E0 sets `flag` at edge E2. The flag is low after E1 and high after E2, because of the two-flop synchronizer and the flag register.
- R3: With `filt_en` at 1, the filtered level changes only after four consecutive equal synchronized samples. A qualifying change that is held sets `flag` at edge E6. A pulse of three cycles or fewer never sets it.
- R4: `edge_rise` at 1 selects rising edges of the (filtered) level and at 0 selects falling edges. An edge of the other polarity does not set `flag`.
- R5: `flag` is sticky. Once set it stays 1 until one of the clear sources in R6 or R7 acts.
- R6: `vec_ack` sampled high at an edge clears `flag` at that same edge.
- R7: `clr_wr` sampled high at edge W leaves `flag` unchanged at W and clears it at edge W+1.
- R8: A new edge event at the same clock edge as a clear wins, so `flag` is 1 after that edge.
- R9: `irq_req` is 1 exactly when `gie`, `irq_en` and `flag` are all 1.
- R10: `flag` is set by events regardless of `irq_en` and `gie`.
- R11: After reset `flag` and `irq_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_level | input | 1 | Level read back from the fault pad |
| cmp_out | input | 1 | Analog comparator output |
| src_cmp_sel | input | 1 | 1: comparator is the fault source, 0: pad |
| filt_en | input | 1 | 1: four-sample noise canceler in the path |
| edge_rise | input | 1 | 1: rising edges trigger, 0: falling edges |
| irq_en | input | 1 | Fault interrupt enable |
| gie | input | 1 | Global interrupt enable |
| clr_wr | input | 1 | Write-one-to-clear strobe for the flag |
| vec_ack | input | 1 | Interrupt vector acknowledge strobe |
| flag | output | 1 | Sticky fault event flag |
| irq_req | output | 1 | Fault interrupt request |

## Verification
A source change that is set up before edge E0 shows on `flag` after E2 when the filter is off and after E6 when it is on. A vector acknowledge acts at its own edge. A write-one clear acts one edge after its strobe. `irq_req` follows its three inputs within the same cycle. Inputs are driven on falling edges and outputs are sampled on falling edges. The directed checks wait the exact number of rising edges given above and then sample, including the edge just before the due cycle. A cycle-level reference model that uses a run counter in place of a sample window is compared against `flag` and `irq_req` on every falling edge, both during the random phase and during the directed phase.

// File: rtl/fg_pkg.sv
package fg_pkg;
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_pol_e;

   localparam int unsigned FG_MIN_SYNC    = 2;
   localparam int unsigned FG_MIN_SAMPLES = 2;
endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import fg_pkg::*;

   if (STAGES < FG_MIN_SYNC) begin : g_bad_stages
      $error("fg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fg_filter.sv
module fg_filter #(
   parameter int unsigned SAMPLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic level_q
);
   import fg_pkg::*;

   if (SAMPLES < FG_MIN_SAMPLES) begin : g_bad_samples
      $error("fg_filter: SAMPLES must be at least 2");
   end

   localparam int unsigned HIST_W = SAMPLES - 1;

   logic [HIST_W-1:0]  hist_q;
   logic [SAMPLES-1:0] window;
   logic               all_hi;
   logic               all_lo;

   assign window = {hist_q, d};
   assign all_hi = &window;
   assign all_lo = ~|window;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q  <= '0;
         level_q <= 1'b0;
      end else begin
         if (HIST_W > 1) hist_q <= {hist_q[HIST_W-2:0], d};
         else            hist_q <= d;
         if (all_hi)      level_q <= 1'b1;
         else if (all_lo) level_q <= 1'b0;
      end
   end

   AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level_q) |-> (level_q == $past(d))) else $error("filter moved against its input"); // R3
endmodule

// File: rtl/fg_flag.sv
module fg_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic edge_rise,
   input  logic vec_ack,
   input  logic clr_wr,
   output logic flag_q
);
   import fg_pkg::*;

   logic      prev_q;
   logic      pend_q;
   logic      evt;
   edge_pol_e pol;

   assign pol = edge_pol_e'(edge_rise);
   assign evt = (pol == EDGE_RISE) ? (level & ~prev_q) : (~level & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= level;
         pend_q <= clr_wr;
         if (evt)                    flag_q <= 1'b1;
         else if (vec_ack || pend_q) flag_q <= 1'b0;
      end
   end

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack && !evt) |=> !flag_q) else $error("ack did not clear"); // R6
   AST_WR_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && clr_wr && !vec_ack && !pend_q) |=> flag_q) else $error("write clear too early"); // R7
   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !evt) |=> !flag_q) else $error("write clear lost"); // R7
   AST_SET_ON_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> ($past(edge_rise) ? $past(level) : !$past(level))) else $error("wrong polarity"); // R4
endmodule

// File: rtl/fault_guard.sv
module fault_guard #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_SAMPLES = 4,
   parameter bit          HAS_FILTER  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pad_level,
   input  logic cmp_out,
   input  logic src_cmp_sel,
   input  logic filt_en,
   input  logic edge_rise,
   input  logic irq_en,
   input  logic gie,
   input  logic clr_wr,
   input  logic vec_ack,
   output logic flag,
   output logic irq_req
);
   logic src_raw;
   logic src_sync;
   logic src_filt;
   logic lvl;

   assign src_raw = src_cmp_sel ? cmp_out : pad_level;

   fg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (src_raw),
      .q    (src_sync)
   );

   if (HAS_FILTER) begin : g_filter
      fg_filter #(.SAMPLES(FILT_SAMPLES)) u_filter (
         .clk    (clk),
         .rst_n  (rst_n),
         .d      (src_sync),
         .level_q(src_filt)
      );
      assign lvl = filt_en ? src_filt : src_sync;
   end else begin : g_no_filter
      assign src_filt = src_sync;
      assign lvl      = src_sync;
   end

   fg_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (lvl),
      .edge_rise(edge_rise),
      .vec_ack  (vec_ack),
      .clr_wr   (clr_wr),
      .flag_q   (flag)
   );

   assign irq_req = gie & irq_en & flag;

   AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (flag && gie)) else $error("request without flag"); // R9
endmodule

// File: tb/fault_guard_bench.sv
module fault_guard_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pad_level = 0, cmp_out = 0, src_cmp_sel = 0, filt_en = 0, edge_rise = 1;
   logic irq_en = 1, gie = 1, clr_wr = 0, vec_ack = 0;
   logic flag, irq_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fault_guard u_fault_guard (
      .clk(clk), .rst_n(rst_n), .pad_level(pad_level), .cmp_out(cmp_out),
      .src_cmp_sel(src_cmp_sel), .filt_en(filt_en), .edge_rise(edge_rise),
      .irq_en(irq_en), .gie(gie), .clr_wr(clr_wr), .vec_ack(vec_ack),
      .flag(flag), .irq_req(irq_req)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic exp_irq(input logic g, input logic e, input logic f);
      return g & e & f;
   endfunction

   // Reference model: run counter in place of a sample window
   logic m_s1, m_s2, m_last, m_filt, m_prev, m_pend, m_flag;
   int   m_run;
   always @(posedge clk) begin
      logic sel, lvl, ev, nf;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_last = 0; m_filt = 0; m_prev = 0;
         m_pend = 0; m_flag = 0; m_run = 3;
      end else begin
         sel = src_cmp_sel ? cmp_out : pad_level;
         lvl = filt_en ? m_filt : m_s2;
         ev  = edge_rise ? (lvl & ~m_prev) : (~lvl & m_prev);
         nf  = ev ? 1'b1 : ((vec_ack | m_pend) ? 1'b0 : m_flag);
         if (m_s2 == m_last) m_run = (m_run < 7) ? m_run + 1 : 7;
         else                m_run = 1;
         m_last = m_s2;
         if (m_run >= 4) m_filt = m_s2;
         m_prev = lvl;
         m_pend = clr_wr;
         m_flag = nf;
         m_s2 = m_s1;
         m_s1 = sel;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 model flag", flag, m_flag);
         chk("R9 model irq", irq_req, exp_irq(gie, irq_en, m_flag));
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      step(3);
      chk("R11 reset flag", flag, 1'b0);
      chk("R11 reset irq", irq_req, 1'b0);
      rst_n = 1'b1;
      step(2);

      // R2: unfiltered latency, rising edge on pad
      pad_level = 1; step(2);
      chk("R2 flag before E2", flag, 1'b0);
      step(1);
      chk("R2 flag at E2", flag, 1'b1);
      step(10);
      chk("R5 sticky", flag, 1'b1);

      // R9 / R10: request gating
      gie = 0; #1;
      chk("R9 gie low", irq_req, 1'b0);
      gie = 1; #1;
      chk("R9 all high", irq_req, 1'b1);
      irq_en = 0; #1;
      chk("R9 irq_en low", irq_req, 1'b0);
      chk("R10 flag kept", flag, 1'b1);
      irq_en = 1;
      @(negedge clk);

      // R6: vector acknowledge
      vec_ack = 1; step(1); vec_ack = 0;
      chk("R6 ack clears", flag, 1'b0);

      // R3: filtered path, falling edges
      filt_en = 1; edge_rise = 0; step(2);
      pad_level = 0; step(3); pad_level = 1; step(10);
      chk("R3 short pulse ignored", flag, 1'b0);
      pad_level = 0; step(6);
      chk("R3 flag before E6", flag, 1'b0);
      step(1);
      chk("R3 flag at E6", flag, 1'b1);

      // R7: write-one clear delayed
      clr_wr = 1; step(1); clr_wr = 0;
      chk("R7 held one cycle", flag, 1'b1);
      step(1);
      chk("R7 cleared", flag, 1'b0);

      // R4: rising edge ignored in falling mode
      pad_level = 1; step(10);
      chk("R4 opposite edge ignored", flag, 1'b0);
      pad_level = 0; filt_en = 0; edge_rise = 1; step(6);
      chk("R4 falling ignored in rising mode", flag, 1'b0);

      // R1: source select
      cmp_out = 1; step(4); cmp_out = 0; step(4);
      chk("R1 comparator ignored", flag, 1'b0);
      src_cmp_sel = 1; step(4);
      cmp_out = 1; step(3);
      chk("R1 comparator selected", flag, 1'b1);
      vec_ack = 1; step(1); vec_ack = 0;
      pad_level = 1; step(4); pad_level = 0; step(4);
      chk("R1 pad ignored", flag, 1'b0);

      // R8: set wins over simultaneous ack
      cmp_out = 0; step(5);
      cmp_out = 1; step(2);
      vec_ack = 1; step(1); vec_ack = 0;
      chk("R8 set beats clear", flag, 1'b1);

      // Random phase
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(5, 0) == 0)  pad_level   = ~pad_level;
         if ($urandom_range(5, 0) == 0)  cmp_out     = ~cmp_out;
         if ($urandom_range(49, 0) == 0) src_cmp_sel = ~src_cmp_sel;
         if ($urandom_range(49, 0) == 0) filt_en     = ~filt_en;
         if ($urandom_range(39, 0) == 0) edge_rise   = ~edge_rise;
         if ($urandom_range(9, 0) == 0)  gie         = ~gie;
         if ($urandom_range(9, 0) == 0)  irq_en      = ~irq_en;
         vec_ack = ($urandom_range(19, 0) == 0);
         clr_wr  = ($urandom_range(14, 0) == 0);
         step(1);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule